// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

The sequencer holds the micro-address of a microcoded control store and works out the next one every clock. Each cycle it is given the decoded type of the current micro-instruction, a 4-bit condition select, a 4-bit target field, sixteen condition inputs and an entry address for the next machine instruction. From these it advances by one, branches, calls, returns or starts a new instruction. The control store contents and the datapath moves belong to other blocks.

Branches are conditional. A match stage works like a PLA: one row per condition, and each row fires when its code is selected and its input is high. Condition code 15 is the external branch-condition-met signal, and codes 0 to 14 come from a 15-bit condition bus. A short jump stays inside the current 16-word block. A long jump takes its destination from a fixed 16-entry table. A call takes its destination from a second, separate 16-entry table. Both tables are parameters. A call stores its return point in a single register, and a return bookkeeping operation restores it.

All pins are plain control and status signals. The block moves no data stream, so it has no valid/ready handshake and no back-pressure. One decision is made on every clock.

Top module: `useq_next_addr`

## Requirements
- R1: While rst_n is low, uaddr is held at RESET_ADDR (default 0) and the return register is cleared to 0.
- R2: The selected condition is cond_in[cond_sel] for codes 0 to 14 and branch_met for code 15. Every unselected condition input has no effect on uaddr.
- R3: When uop_type is 0 (short jump) and the selected condition is true, the next uaddr keeps the current bits above bit 3 and takes target as its low 4 bits.
- R4: When uop_type is 5 (long jump) and the selected condition is true, the next uaddr is JMP_TBL[target].
- R5: When uop_type is 7 (call) and the selected condition is true, the next uaddr is CALL_TBL[target] and the return register is loaded with the current uaddr plus one.
- R6: When uop_type is 0, 5 or 7 and the selected condition is false, the next uaddr is the current uaddr plus one. An untaken call leaves the return register unchanged.
- R7: uop_type 1 (ALU), 6 (memory) and the unused codes 2 and 3 advance uaddr by one, as does 4 (bookkeeping) when neither end_instr nor ret_op is set. Incrementing wraps from all ones to 0.
- R8: When end_instr is high and uop_type is 1, 4 or 6, the next uaddr is entry_addr. With uop_type 0, 2, 3, 5 or 7, end_instr is ignored.
- R9: When uop_type is 4, ret_op is high and end_instr is low, the next uaddr is the return register. end_instr takes priority over ret_op, and ret_op is ignored with every other type.
- R10: The return register holds one level only: a second taken call replaces the saved return point of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| uop_type | input | 3 | Decoded micro-instruction type: 0 short jump, 1 ALU, 4 bookkeeping, 5 long jump, 6 memory, 7 call |
| cond_sel | input | 4 | Condition select code |
| target | input | 4 | Short-jump low bits, or table index for a long jump or call |
| cond_in | input | 15 | Conditions for codes 0 to 14 |
| branch_met | input | 1 | Condition 15: external branch-condition-met |
| end_instr | input | 1 | End of machine instruction; load entry_addr |
| entry_addr | input | AW (13) | Entry micro-address of the next machine instruction |
| ret_op | input | 1 | Return request, valid with bookkeeping type |
| uaddr | output | AW (13) | Current micro-address |

## Verification
Any wrong decision shows on uaddr at the very next rising edge, because the next address goes straight into the output register. A fault in the match stage shows up in two ways: a condition that is not selected steers a branch, or a selected condition fails to steer one. Each of the sixteen codes is therefore driven both one-hot and as the only zero. The return register cannot be seen directly. A corrupted, missed or extra save appears only when a later return lands on the wrong address, so every call scenario ends with a return.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int NCOND = 16;
  localparam int SEL_W = $clog2(NCOND);
  localparam int BLK_W = 4;
  localparam int NTGT  = 16;
  localparam int TGT_W = $clog2(NTGT);

  typedef enum logic [2:0] {
    UT_SHORT = 3'd0,
    UT_ALU   = 3'd1,
    UT_RSV2  = 3'd2,
    UT_RSV3  = 3'd3,
    UT_BOOK  = 3'd4,
    UT_LJMP  = 3'd5,
    UT_MEM   = 3'd6,
    UT_LCALL = 3'd7
  } utype_e;

endpackage

// File: rtl/useq_cond_pla.sv
module useq_cond_pla #(
  parameter int NC = 16,
  parameter int SW = $clog2(NC)
) (
  input  logic [SW-1:0] sel,
  input  logic [NC-1:0] conds,
  output logic          met
);

  logic [NC-1:0] row;

  // one product term per condition: code match AND condition high
  for (genvar g = 0; g < NC; g++) begin : g_row
    assign row[g] = (sel == SW'(g)) && conds[g];
  end

  assign met = |row;

endmodule

// File: rtl/useq_target_table.sv
module useq_target_table #(
  parameter int AW = 13,
  parameter int N  = 16,
  parameter int IW = $clog2(N),
  parameter logic [N-1:0][AW-1:0] TBL = '0
) (
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);

  // decoded lookup: each entry gated by its own index match, then ORed
  always_comb begin
    addr = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IW'(i)) addr = addr | TBL[i];
    end
  end

endmodule

// File: rtl/useq_return_reg.sv
module useq_return_reg #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save,
  input  logic [AW-1:0] save_val,
  output logic [AW-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (save) value <= save_val;
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int AW = 13,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  parameter logic [NTGT-1:0][AW-1:0] JMP_TBL = {
    AW'(13'h0F00), AW'(13'h0E20), AW'(13'h0D40), AW'(13'h0C60),
    AW'(13'h0B80), AW'(13'h0AA0), AW'(13'h09C0), AW'(13'h08E0),
    AW'(13'h0700), AW'(13'h0620), AW'(13'h0540), AW'(13'h0460),
    AW'(13'h0380), AW'(13'h02A0), AW'(13'h01C0), AW'(13'h00E0)},
  parameter logic [NTGT-1:0][AW-1:0] CALL_TBL = {
    AW'(13'h1F10), AW'(13'h1E30), AW'(13'h1D50), AW'(13'h1C70),
    AW'(13'h1B90), AW'(13'h1AB0), AW'(13'h19D0), AW'(13'h18F0),
    AW'(13'h1710), AW'(13'h1630), AW'(13'h1550), AW'(13'h1470),
    AW'(13'h1390), AW'(13'h12B0), AW'(13'h11D0), AW'(13'h10F0)}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          uop_type,
  input  logic [SEL_W-1:0]    cond_sel,
  input  logic [TGT_W-1:0]    target,
  input  logic [NCOND-2:0]    cond_in,
  input  logic                branch_met,
  input  logic                end_instr,
  input  logic [AW-1:0]       entry_addr,
  input  logic                ret_op,
  output logic [AW-1:0]       uaddr
);

  localparam int HI_W = AW - BLK_W;

  logic [NCOND-1:0] all_conds;
  logic             cond_met;
  logic [AW-1:0]    jmp_dest;
  logic [AW-1:0]    call_dest;
  logic [AW-1:0]    ret_val;
  logic [AW-1:0]    incr;
  logic [AW-1:0]    nxt;
  logic             save_ret;
  logic [HI_W-1:0]  blk_hi;

  assign all_conds = {branch_met, cond_in};
  assign incr      = uaddr + AW'(1);
  assign blk_hi    = uaddr[AW-1:BLK_W];

  useq_cond_pla #(.NC(NCOND), .SW(SEL_W)) u_pla (
    .sel   (cond_sel),
    .conds (all_conds),
    .met   (cond_met)
  );

  useq_target_table #(.AW(AW), .N(NTGT), .IW(TGT_W), .TBL(JMP_TBL)) u_jmp_tbl (
    .idx  (target),
    .addr (jmp_dest)
  );

  useq_target_table #(.AW(AW), .N(NTGT), .IW(TGT_W), .TBL(CALL_TBL)) u_call_tbl (
    .idx  (target),
    .addr (call_dest)
  );

  useq_return_reg #(.AW(AW)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .save     (save_ret),
    .save_val (incr),
    .value    (ret_val)
  );

  always_comb begin
    nxt      = incr;
    save_ret = 1'b0;
    case (utype_e'(uop_type))
      UT_SHORT: if (cond_met) nxt = {blk_hi, target};
      UT_LJMP:  if (cond_met) nxt = jmp_dest;
      UT_LCALL: begin
        if (cond_met) begin
          nxt      = call_dest;
          save_ret = 1'b1;
        end
      end
      UT_ALU, UT_MEM: if (end_instr) nxt = entry_addr;
      UT_BOOK: begin
        if (end_instr)   nxt = entry_addr;
        else if (ret_op) nxt = ret_val;
      end
      default: nxt = incr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uaddr <= RESET_ADDR;
    else        uaddr <= nxt;
  end

endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk
  import useq_pkg::*;
#(
  parameter int AW = 13,
  parameter logic [NTGT-1:0][AW-1:0] JMP_TBL = '0,
  parameter logic [NTGT-1:0][AW-1:0] CALL_TBL = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       uop_type,
  input logic [SEL_W-1:0] cond_sel,
  input logic [TGT_W-1:0] target,
  input logic [NCOND-2:0] cond_in,
  input logic             branch_met,
  input logic             end_instr,
  input logic [AW-1:0]    entry_addr,
  input logic             ret_op,
  input logic [AW-1:0]    uaddr
);

  logic [NCOND-1:0] conds_v;
  logic             sel_true;
  logic             is_br;
  logic             is_seq;
  logic             is_endable;

  assign conds_v    = {branch_met, cond_in};
  assign sel_true   = conds_v[cond_sel];
  assign is_br      = (uop_type == 3'd0) || (uop_type == 3'd5) || (uop_type == 3'd7);
  assign is_endable = (uop_type == 3'd1) || (uop_type == 3'd4) || (uop_type == 3'd6);
  assign is_seq     = (uop_type == 3'd2) || (uop_type == 3'd3) ||
                      (((uop_type == 3'd1) || (uop_type == 3'd6)) && !end_instr) ||
                      ((uop_type == 3'd4) && !end_instr && !ret_op);

  p_short_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_type == 3'd0 && sel_true) |=>
      uaddr == {$past(uaddr[AW-1:BLK_W]), $past(target)});

  p_long_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_type == 3'd5 && sel_true) |=> uaddr == JMP_TBL[$past(target)]);

  p_call_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_type == 3'd7 && sel_true) |=> uaddr == CALL_TBL[$past(target)]);

  p_untaken_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_br && !sel_true) |=> uaddr == $past(uaddr) + AW'(1));

  p_seq_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_seq |=> uaddr == $past(uaddr) + AW'(1));

  p_end_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_endable && end_instr) |=> uaddr == $past(entry_addr));

endmodule

bind useq_next_addr useq_next_addr_chk #(
  .AW(AW), .JMP_TBL(JMP_TBL), .CALL_TBL(CALL_TBL)
) u_chk (.*);

// File: tb/useq_next_addr_bench.sv
module useq_next_addr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  function automatic logic [15:0][AW-1:0] mk_tbl(input logic [AW-1:0] base,
                                                 input logic [AW-1:0] stride);
    logic [15:0][AW-1:0] t;
    for (int i = 0; i < 16; i++) t[i] = base + AW'(i) * stride;
    return t;
  endfunction

  localparam logic [15:0][AW-1:0] JT = mk_tbl(13'h0800, 13'd9);
  localparam logic [15:0][AW-1:0] CT = mk_tbl(13'h1000, 13'd17);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    uop_type = 3'd1;
  logic [3:0]    cond_sel = '0;
  logic [3:0]    target = '0;
  logic [14:0]   cond_in = '0;
  logic          branch_met = 1'b0;
  logic          end_instr = 1'b0;
  logic [AW-1:0] entry_addr = '0;
  logic          ret_op = 1'b0;
  logic [AW-1:0] uaddr;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [AW-1:0] exp_ret = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_next_addr #(.AW(AW), .RESET_ADDR('0), .JMP_TBL(JT), .CALL_TBL(CT)) u_useq_next_addr (
    .clk(clk), .rst_n(rst_n), .uop_type(uop_type), .cond_sel(cond_sel),
    .target(target), .cond_in(cond_in), .branch_met(branch_met),
    .end_instr(end_instr), .entry_addr(entry_addr), .ret_op(ret_op), .uaddr(uaddr)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: uaddr=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one micro-instruction for one clock and compare with the expected next address
  task automatic step(input string req, input logic [2:0] t, input logic [3:0] sel,
                      input logic [3:0] tg, input logic [14:0] ci, input logic bm,
                      input logic en, input logic [AW-1:0] ent, input logic rop);
    logic met;
    logic [AW-1:0] nx;
    logic [AW-1:0] nr;
    uop_type = t; cond_sel = sel; target = tg; cond_in = ci; branch_met = bm;
    end_instr = en; entry_addr = ent; ret_op = rop;
    met = (sel == 4'd15) ? bm : ci[sel];
    nx = exp_addr + 13'd1;
    nr = exp_ret;
    case (t)
      3'd0: if (met) nx = {exp_addr[AW-1:4], tg};
      3'd5: if (met) nx = JT[tg];
      3'd7: if (met) begin nx = CT[tg]; nr = exp_addr + 13'd1; end
      3'd1, 3'd6: if (en) nx = ent;
      3'd4: if (en) nx = ent; else if (rop) nx = exp_ret;
      default: ;
    endcase
    @(posedge clk); #1;
    exp_addr = nx;
    exp_ret = nr;
    check(req, uaddr, exp_addr);
  endtask

  task automatic go_to(input logic [AW-1:0] a);
    step("R8", 3'd1, 4'd0, 4'd0, 15'h0, 1'b0, 1'b1, a, 1'b0);
  endtask

  task automatic t_reset;
    check("R1", uaddr, 13'h0000);
    step("R1 R9", 3'd4, 4'd0, 4'd0, 15'h0, 1'b0, 1'b0, 13'h1234, 1'b1);
  endtask

  task automatic t_seq;
    go_to(13'h0040);
    step("R7", 3'd1, 4'd0, 4'd0, 15'h7FFF, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R7", 3'd6, 4'd0, 4'd0, 15'h7FFF, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R7", 3'd4, 4'd0, 4'd0, 15'h7FFF, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R7", 3'd2, 4'd0, 4'd0, 15'h7FFF, 1'b1, 1'b1, 13'h0AAA, 1'b1);
    step("R7", 3'd3, 4'd0, 4'd0, 15'h7FFF, 1'b1, 1'b1, 13'h0AAA, 1'b1);
    go_to(13'h1FFF);
    step("R7 wrap", 3'd1, 4'd0, 4'd0, 15'h0, 1'b0, 1'b0, 13'h0, 1'b0);
  endtask

  task automatic t_end;
    step("R8", 3'd6, 4'd0, 4'd0, 15'h0, 1'b0, 1'b1, 13'h0321, 1'b0);
    step("R8", 3'd4, 4'd0, 4'd0, 15'h0, 1'b0, 1'b1, 13'h0555, 1'b0);
    step("R8 ignored", 3'd0, 4'd2, 4'd9, 15'h0, 1'b0, 1'b1, 13'h0777, 1'b0);
    step("R8 ignored", 3'd5, 4'd1, 4'd3, 15'h0002, 1'b0, 1'b1, 13'h0777, 1'b0);
  endtask

  task automatic t_short;
    go_to(13'h0123);
    step("R3", 3'd0, 4'd3, 4'hA, 15'h0008, 1'b0, 1'b0, 13'h0, 1'b0);
    step("R6", 3'd0, 4'd3, 4'h0, 15'h7FF7, 1'b1, 1'b0, 13'h0, 1'b0);
    go_to(13'h01FF);
    step("R6 block", 3'd0, 4'd0, 4'h5, 15'h0, 1'b0, 1'b0, 13'h0, 1'b0);
    step("R3 low", 3'd0, 4'd0, 4'h0, 15'h0001, 1'b0, 1'b0, 13'h0, 1'b0);
  endtask

  task automatic t_cond_sweep;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] oh;
      oh = 16'h1 << i;
      go_to(13'h0200);
      step("R2 one-hot", 3'd5, 4'(i), 4'(i), oh[14:0], oh[15], 1'b0, 13'h0, 1'b0);
      step("R2 one-cold", 3'd5, 4'(i), 4'(i), ~oh[14:0], ~oh[15], 1'b0, 13'h0, 1'b0);
    end
  endtask

  task automatic t_ljmp;
    step("R4", 3'd5, 4'd15, 4'd0, 15'h0, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R4", 3'd5, 4'd15, 4'd15, 15'h0, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R6", 3'd5, 4'd15, 4'd7, 15'h7FFF, 1'b0, 1'b0, 13'h0, 1'b0);
  endtask

  task automatic t_call;
    go_to(13'h0300);
    step("R5", 3'd7, 4'd4, 4'd2, 15'h0010, 1'b0, 1'b0, 13'h0, 1'b0);
    step("R6", 3'd7, 4'd4, 4'd9, 15'h0, 1'b0, 1'b0, 13'h0, 1'b0);
    step("R9 ignored", 3'd1, 4'd0, 4'd0, 15'h0, 1'b0, 1'b0, 13'h0, 1'b1);
    step("R9", 3'd4, 4'd0, 4'd0, 15'h0, 1'b0, 1'b0, 13'h0, 1'b1);
    step("R5", 3'd7, 4'd15, 4'd5, 15'h0, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R10", 3'd7, 4'd15, 4'd11, 15'h0, 1'b1, 1'b0, 13'h0, 1'b0);
    step("R9 end wins", 3'd4, 4'd0, 4'd0, 15'h0, 1'b0, 1'b1, 13'h0444, 1'b1);
    step("R10", 3'd4, 4'd0, 4'd0, 15'h0, 1'b0, 1'b0, 13'h0, 1'b1);
    step("R9 ignored", 3'd6, 4'd0, 4'd0, 15'h0, 1'b0, 1'b0, 13'h0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_seq();
    t_end();
    t_short();
    t_cond_sweep();
    t_ljmp();
    t_call();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule